// File: doc/BRIEF.md
# Serial Diagnostic and Control Port

This block is the slave side of a four-wire synchronous serial port that sits between a host and the fault logic of a multi-channel low-side driver. The host drives a chip select, a serial clock and a read/write select. One bidirectional data line carries diagnostics out or control bits in. All three control lines and the incoming data are sampled by the faster system clock through multi-flop synchronisers, and every protocol event is taken from their edges.

A session starts only when chip select falls while the serial clock is high. At that moment the block captures a frame built from the latched fault flags and the live comparator states. It drives a summary bit at once, before any clock edge. With read/write high, the frame leaves most-significant first and advances on each rising serial clock. The first falling serial clock of a read session issues a one-cycle clear request to the fault logic. With read/write low, the data line becomes an input: bits are sampled on falling serial clock edges, and the last six are committed to a control store when chip select rises. The pad itself is outside the block, which provides only an output value and an output enable.

The serial protocol has no back-pressure. The host owns the clock, so the block must accept or present one bit per serial clock edge. No valid/ready pair is present at the edge.

Top module: `serdiag_if`

## Requirements
- R1: After reset the data output enable is 0, no clear request is issued, and all six control outputs (four open-load delay selects, test mode, low current-limit select) are 0.
- R2: When chip select falls while the serial clock is high and read/write is high, the output enable rises and the data output shows the summary bit: the OR of the over-temperature, short, open-load and ground-short fault inputs of all channels.
- R3: The read frame is 22 bits, in this order: summary, over-temperature, then for channel 1 to 4 in turn the short, open-load and ground-short flags, then the raw open-load comparators of channels 1 to 4, then the raw ground-short comparators of channels 1 to 4. Each rising serial clock edge in a read session advances the output by one bit.
- R4: Bits shifted out after the 22-bit frame are 0.
- R5: The first falling serial clock edge of a read session produces exactly one single-cycle clear request. Later falling edges in the same session produce none.
- R6: The output enable is 0 while chip select is high and while read/write is low.
- R7: In a write session, data is sampled on each falling serial clock edge. When chip select rises, the last six bits received are committed in arrival order to: delay select of channel 1, 2, 3, 4, then test mode, then low current-limit select. Earlier bits, such as the two leading dummies of an 8-bit frame, are dropped.
- R8: A write session that ends with fewer than six sampled bits leaves the control outputs unchanged.
- R9: A write session produces no clear request, and a read session leaves the control outputs unchanged.
- R10: If chip select falls while the serial clock is low, no session opens. The output enable stays 0, clock toggles produce no clear request, and the control outputs do not change.
- R11: The frame contents are captured at the chip-select fall. Changes on the fault or comparator inputs after that do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| rw_i | input | 1 | Read (1) / write (0) select |
| sdata_i | input | 1 | Data line as seen at the pad |
| sdata_o | output | 1 | Value driven onto the data line |
| sdata_oe_o | output | 1 | Drive enable for the data line |
| fault_hot_i | input | 1 | Latched over-temperature flag |
| fault_short_i | input | NCH | Latched short flags, bit 0 = channel 1 |
| fault_open_i | input | NCH | Latched open-load flags |
| fault_gnd_i | input | NCH | Latched ground-short flags |
| raw_open_i | input | NCH | Live open-load comparator states |
| raw_gnd_i | input | NCH | Live ground-short comparator states |
| diag_clear_o | output | 1 | One-cycle request to clear the latched flags |
| ol_dly_short_o | output | NCH | Open-load delay selects, bit 0 = channel 1 |
| test_mode_o | output | 1 | Test mode control bit |
| ilim_low_o | output | 1 | Low current-limit select for the high-current channels |

## Verification
The bench reads past the end of the frame. A design that filled the shift register with anything but zero would leak stale bits there. It changes the comparator inputs in mid-read, which catches a frame that is sampled live instead of captured at the chip-select fall. It opens sessions with the clock low and writes frames of four, six and eight bits. A wrong guard would open a false session or commit a partial write, and a wrong tap would lose the dummy bits in the wrong place. Clear requests are counted over reads and writes, which exposes a clear that repeats on every falling edge or that fires during a write.

// File: rtl/serdiag_pkg.sv
`timescale 1ns/1ps
package serdiag_pkg;
  parameter int unsigned DEF_NCH    = 4;
  parameter int unsigned DEF_STAGES = 2;

  function automatic int unsigned frame_bits(int unsigned nch);
    return 2 + 5 * nch;
  endfunction

  function automatic int unsigned store_bits(int unsigned nch);
    return nch + 2;
  endfunction
endpackage

// File: rtl/serdiag_sync.sv
`timescale 1ns/1ps
module serdiag_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/serdiag_rd_shift.sv
`timescale 1ns/1ps
module serdiag_rd_shift #(
  parameter int unsigned FRAME_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               head_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      shifted <= '0;
    end else if (load_i) begin
      shreg   <= frame_i;
      shifted <= '0;
    end else if (shift_i) begin
      shreg <= {shreg[FRAME_W-2:0], 1'b0};
      if (shifted != CNT_W'(FRAME_W)) shifted <= shifted + 1'b1;
    end
  end

  assign head_o = shreg[FRAME_W-1];

  AST_FRAME_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (shreg == $past(frame_i))); // R11
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (shifted == CNT_W'(FRAME_W)) |-> (shreg == '0)); // R4
endmodule

// File: rtl/serdiag_wr_store.sv
`timescale 1ns/1ps
module serdiag_wr_store #(
  parameter int unsigned STORE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               sample_i,
  input  logic               bit_i,
  input  logic               commit_i,
  output logic [STORE_W-1:0] store_o
);
  localparam int unsigned CNT_W = $clog2(STORE_W + 1);

  logic [STORE_W-1:0] inbuf;
  logic [CNT_W-1:0]   taken;
  logic [STORE_W-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inbuf <= '0;
      taken <= '0;
    end else if (start_i) begin
      inbuf <= '0;
      taken <= '0;
    end else if (sample_i) begin
      inbuf <= {inbuf[STORE_W-2:0], bit_i};
      if (taken != CNT_W'(STORE_W)) taken <= taken + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else if (commit_i && taken == CNT_W'(STORE_W)) store_q <= inbuf;
  end

  assign store_o = store_q;

  AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(store_q)); // R9
  AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && taken != CNT_W'(STORE_W)) |=> $stable(store_q)); // R8
endmodule

// File: rtl/serdiag_if.sv
`timescale 1ns/1ps
module serdiag_if #(
  parameter int unsigned NCH         = serdiag_pkg::DEF_NCH,
  parameter int unsigned SYNC_STAGES = serdiag_pkg::DEF_STAGES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n_i,
  input  logic           sclk_i,
  input  logic           rw_i,
  input  logic           sdata_i,
  output logic           sdata_o,
  output logic           sdata_oe_o,
  input  logic           fault_hot_i,
  input  logic [NCH-1:0] fault_short_i,
  input  logic [NCH-1:0] fault_open_i,
  input  logic [NCH-1:0] fault_gnd_i,
  input  logic [NCH-1:0] raw_open_i,
  input  logic [NCH-1:0] raw_gnd_i,
  output logic           diag_clear_o,
  output logic [NCH-1:0] ol_dly_short_o,
  output logic           test_mode_o,
  output logic           ilim_low_o
);
  localparam int unsigned FRAME_W = serdiag_pkg::frame_bits(NCH);
  localparam int unsigned STORE_W = serdiag_pkg::store_bits(NCH);

  // synchronised lines: {cs_n, sclk, rw, data}
  logic [3:0] sync_v;
  logic cs_s, sclk_s, rw_s, din_s;

  serdiag_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({cs_n_i, sclk_i, rw_i, sdata_i}),
    .sync_o(sync_v)
  );
  assign {cs_s, sclk_s, rw_s, din_s} = sync_v;

  logic cs_q, sclk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  logic cs_fall, cs_rise, sclk_rise, sclk_fall, load;
  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = ~cs_q & cs_s;
  assign sclk_rise = ~sclk_q & sclk_s;
  assign sclk_fall = sclk_q & ~sclk_s;
  assign load      = cs_fall & sclk_s;

  // session control
  logic active, first_pend, clr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      first_pend <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      clr_q <= active & first_pend & sclk_fall & rw_s;
      if (load) begin
        active     <= 1'b1;
        first_pend <= 1'b1;
      end else if (cs_rise) begin
        active     <= 1'b0;
        first_pend <= 1'b0;
      end else if (active && sclk_fall) begin
        first_pend <= 1'b0;
      end
    end
  end
  assign diag_clear_o = clr_q;

  // frame assembly
  logic [FRAME_W-1:0] frame;
  logic               summary;
  assign summary = fault_hot_i | (|fault_short_i) | (|fault_open_i) | (|fault_gnd_i);
  assign frame[FRAME_W-1] = summary;
  assign frame[FRAME_W-2] = fault_hot_i;
  for (genvar c = 0; c < NCH; c++) begin : g_frame
    assign frame[FRAME_W-3-3*c] = fault_short_i[c];
    assign frame[FRAME_W-4-3*c] = fault_open_i[c];
    assign frame[FRAME_W-5-3*c] = fault_gnd_i[c];
    assign frame[2*NCH-1-c]     = raw_open_i[c];
    assign frame[NCH-1-c]       = raw_gnd_i[c];
  end

  logic head;
  serdiag_rd_shift #(.FRAME_W(FRAME_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .load_i(load),
    .shift_i(active & rw_s & sclk_rise),
    .frame_i(frame),
    .head_o(head)
  );

  logic [STORE_W-1:0] store;
  serdiag_wr_store #(.STORE_W(STORE_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .start_i(load),
    .sample_i(active & ~rw_s & sclk_fall),
    .bit_i(din_s),
    .commit_i(active & cs_rise),
    .store_o(store)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_store
    assign ol_dly_short_o[c] = store[STORE_W-1-c];
  end
  assign test_mode_o = store[1];
  assign ilim_low_o  = store[0];

  assign sdata_oe_o = active & rw_s & ~cs_s;
  assign sdata_o    = sdata_oe_o ? head : 1'b0;

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clear_o |=> !diag_clear_o); // R5
  AST_CLEAR_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clear_o |-> $past(rw_s)); // R9
  AST_NO_SESSION_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !sclk_s) |=> !sdata_oe_o); // R10
  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |-> !sdata_oe_o); // R6
endmodule

// File: tb/tb_serdiag_if.sv
`timescale 1ns/1ps
module tb_serdiag_if;
  localparam int NCH = 4;
  localparam int FW  = 22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, rw = 1'b1, din = 1'b0;
  logic dout, doe, clr, test_m, ilim;
  logic hot = 1'b0;
  logic [NCH-1:0] f_sc = '0, f_ol = '0, f_sg = '0, r_ol = '0, r_sg = '0, dly;

  serdiag_if dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .rw_i(rw),
    .sdata_i(din), .sdata_o(dout), .sdata_oe_o(doe),
    .fault_hot_i(hot), .fault_short_i(f_sc), .fault_open_i(f_ol),
    .fault_gnd_i(f_sg), .raw_open_i(r_ol), .raw_gnd_i(r_sg),
    .diag_clear_o(clr), .ol_dly_short_o(dly), .test_mode_o(test_m),
    .ilim_low_o(ilim)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, clears = 0;
  bit cmp_en = 0, done = 0;
  bit exp_oe = 0, exp_out = 0;
  logic [5:0] exp_ctrl = '0;
  string cur_req = "R1";

  always @(negedge clk) if (rst_n && clr) clears++;

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (doe !== exp_oe || (exp_oe && dout !== exp_out) ||
          {dly, test_m, ilim} !== exp_ctrl) begin
        errors++;
        $display("FAIL %s: oe=%0b out=%0b ctrl=%b, expected oe=%0b out=%0b ctrl=%b",
                 cur_req, doe, dout, {dly, test_m, ilim}, exp_oe, exp_out, exp_ctrl);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic settle();
    cmp_en = 0;
    repeat (6) @(posedge clk);
  endtask

  task automatic observe();
    cmp_en = 1;
    repeat (3) @(posedge clk);
    cmp_en = 0;
    #2;
  endtask

  task automatic do_read(int nbits, bit tweak_raw, string req);
    bit q[$];
    q.push_back(hot | (|f_sc) | (|f_ol) | (|f_sg));
    q.push_back(hot);
    for (int c = 0; c < NCH; c++) begin
      q.push_back(f_sc[c]); q.push_back(f_ol[c]); q.push_back(f_sg[c]);
    end
    for (int c = 0; c < NCH; c++) q.push_back(r_ol[c]);
    for (int c = 0; c < NCH; c++) q.push_back(r_sg[c]);
    cur_req = req;
    cs_n = 0; settle();
    exp_oe = 1; exp_out = q[0]; observe();
    if (tweak_raw) begin
      r_ol = ~r_ol; r_sg = ~r_sg; f_sc = ~f_sc; settle(); observe();
    end
    for (int i = 0; i < nbits; i++) begin
      sclk = 0; settle(); observe();
      sclk = 1; settle();
      exp_out = (i + 1 < FW) ? q[i+1] : 1'b0;
      observe();
    end
    cs_n = 1; settle(); exp_oe = 0; observe();
  endtask

  task automatic do_write(bit bits[$], string req);
    int n;
    cur_req = req;
    n = bits.size();
    rw = 0; settle(); observe();
    cs_n = 0; settle(); exp_oe = 0; observe();
    foreach (bits[i]) begin
      din = bits[i]; settle();
      sclk = 0; settle(); observe();
      sclk = 1; settle(); observe();
    end
    cs_n = 1; settle();
    if (n >= 6)
      exp_ctrl = {bits[n-3], bits[n-4], bits[n-5], bits[n-6], bits[n-2], bits[n-1]};
    observe();
    rw = 1; settle(); observe();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk); #2;
    cur_req = "R1"; observe();
    check(clears == 0, "R1", clears, 0);

    // R2 R3 R4 R5: fault pattern, read 24 bits
    hot = 1; f_sc = 4'b0100; f_ol = 4'b1001; f_sg = 4'b0010;
    r_ol = 4'b0110; r_sg = 4'b1010;
    c0 = clears;
    do_read(24, 0, "R3");
    check(clears == c0 + 1, "R5", clears - c0, 1);

    // R2 with no latched faults: summary 0; R11 raw change mid-frame
    hot = 0; f_sc = '0; f_ol = '0; f_sg = '0; r_ol = 4'b1100; r_sg = 4'b0011;
    c0 = clears;
    do_read(23, 1, "R11");
    check(clears == c0 + 1, "R5", clears - c0, 1);
    f_sc = '0;

    // R2: single short fault raises summary
    f_sc = 4'b1000; do_read(3, 0, "R2"); f_sc = '0;

    // R7: 8-bit frame with two dummies
    c0 = clears;
    do_write('{1, 1, 1, 0, 1, 1, 0, 1}, "R7");
    check(clears == c0, "R9", clears - c0, 0);

    // R9: read keeps control store
    do_read(4, 0, "R9");

    // R8: short write discarded
    do_write('{0, 0, 0, 0}, "R8");

    // R7: exactly six bits
    do_write('{0, 1, 0, 0, 1, 0}, "R7");

    // R10: chip select falls with clock low
    c0 = clears; cur_req = "R10";
    sclk = 0; settle(); observe();
    cs_n = 0; settle(); exp_oe = 0; observe();
    for (int i = 0; i < 3; i++) begin
      sclk = 1; settle(); observe(); sclk = 0; settle(); observe();
    end
    cs_n = 1; settle(); observe();
    sclk = 1; settle(); observe();
    check(clears == c0, "R10", clears - c0, 0);

    // R6: deselected read/write toggling, and rw low mid-read
    cur_req = "R6";
    rw = 0; settle(); observe(); rw = 1; settle(); observe();
    hot = 1;
    cs_n = 0; settle(); exp_oe = 1; exp_out = 1; observe();
    rw = 0; settle(); exp_oe = 0; observe();
    rw = 1; settle(); exp_oe = 1; observe();
    cs_n = 1; settle(); exp_oe = 0; observe();
    hot = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule